// File: doc/BRIEF.md
# Register-Programmed 32-bit Up-Counting Timer

This block is a timer peripheral for a processor subsystem. A 32-bit counter advances by one on every clock while the timer runs and is compared against a software-programmed terminal value. Software reaches the block through a narrow 16-bit register port: an address, a write strobe with write data, and a read strobe with read data that appears one cycle later. The 32-bit terminal and count values are split into low and high 16-bit halves.

Two run modes exist. In periodic mode the counter wraps to zero after matching the terminal value and keeps running, giving a period of terminal+1 cycles. In one-shot mode the counter stops on the match, the hardware clears the one-shot control bit and the count stays at the terminal value. A completed count sets a pending flag; the interrupt output is that flag gated by the interrupt-enable bit. Reading the low count half captures the high half into a shadow, so a low-then-high read pair always forms one coherent 32-bit sample.

Top module: `mmio_count_timer`

## Requirements
- R1: After reset the control register, terminal value, count, read data and interrupt output are all zero.
- R2: The control register sits at offset 0x00: bit 0 selects periodic running, bit 1 starts a one-shot run, bit 8 enables the interrupt; it reads back as written, except that a write with bits 0 and 1 both set runs periodic and bit 1 reads back 0.
- R3: A control write with bit 0 or bit 1 set restarts the count at zero, and the count then rises by one each clock until it matches the terminal value.
- R4: In periodic mode, on the clock after the count equals the terminal value the count is zero and the pending flag is set, so the match repeats every terminal+1 cycles.
- R5: In one-shot mode, on the clock after the count equals the terminal value the pending flag is set, bit 1 of the control register reads 0, and the count holds at the terminal value.
- R6: A control write with bits 0 and 1 both clear stops the timer; the count keeps its value.
- R7: The interrupt output equals the pending flag ANDed with control bit 8; pending stays set across further matches and restarts until a control write with bit 8 clear, which clears it.
- R8: The terminal value is written and read as a low half at offset 0x08 and a high half at offset 0x0C; a running count only picks up a new value at the next start or the next periodic wrap.
- R9: Reading the low count half at offset 0x10 returns count bits 15:0 and captures bits 31:16 into a shadow; a read of offset 0x14 returns that shadow, not the live count.
- R10: Read data updates on the clock edge where the read strobe is high and holds otherwise; unmapped offsets read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; also the counting tick |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 5 | Byte offset of the accessed register |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_rd | input | 1 | Read strobe, one cycle per read |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, valid the cycle after the read strobe |
| irq | output | 1 | Level interrupt: pending flag gated by enable |

## Verification
The assertions assume that a read and a write never fall in the same cycle and that the address only takes the mapped offsets or harmless unmapped ones while a strobe is high. The counting properties also assume the terminal value only changes through the register port, which is why they compare against the captured active terminal rather than the live register. The directed stimulus drives every strobe for exactly one cycle, never overlaps reads with writes, and changes the address only between accesses.

// File: rtl/mct_pkg.sv
package mct_pkg;
  localparam int CNT_W  = 32;
  localparam int HALF_W = 16;
  localparam int ADDR_W = 5;

  localparam logic [ADDR_W-1:0] OFS_CTRL = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_TLO  = 5'h08;
  localparam logic [ADDR_W-1:0] OFS_THI  = 5'h0C;
  localparam logic [ADDR_W-1:0] OFS_CLO  = 5'h10;
  localparam logic [ADDR_W-1:0] OFS_CHI  = 5'h14;

  localparam int BIT_PER = 0;
  localparam int BIT_ONE = 1;
  localparam int BIT_IEN = 8;

  // Next count while running and not being rewritten by software.
  function automatic logic [CNT_W-1:0] next_count(
    input logic [CNT_W-1:0] cnt,
    input logic             hit,
    input logic             periodic
  );
    if (!hit)          return cnt + 1'b1;
    else if (periodic) return '0;
    else               return cnt;
  endfunction

  // Control register read image.
  function automatic logic [HALF_W-1:0] ctrl_image(
    input logic per, input logic one, input logic ien
  );
    logic [HALF_W-1:0] v;
    v = '0;
    v[BIT_PER] = per;
    v[BIT_ONE] = one;
    v[BIT_IEN] = ien;
    return v;
  endfunction
endpackage

// File: rtl/mct_core.sv
module mct_core
  import mct_pkg::*;
#(
  parameter int W = CNT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ctrl_wr,
  input  logic         wr_per,
  input  logic         wr_one,
  input  logic         wr_ien,
  input  logic [W-1:0] term_in,
  output logic [W-1:0] cnt_q,
  output logic         per_q,
  output logic         one_q,
  output logic         ien_q,
  output logic         pend_q,
  output logic         hit_evt
);
  logic [W-1:0] act_term_q;
  logic         running;
  logic         start_evt;
  logic         stop_evt;
  logic         clear_evt;

  assign running   = per_q | one_q;
  assign hit_evt   = running && !ctrl_wr && (cnt_q == act_term_q);
  assign start_evt = ctrl_wr && (wr_per || wr_one);
  assign stop_evt  = ctrl_wr && !wr_per && !wr_one;
  assign clear_evt = ctrl_wr && !wr_ien;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      act_term_q <= '0;
      per_q      <= 1'b0;
      one_q      <= 1'b0;
      ien_q      <= 1'b0;
      pend_q     <= 1'b0;
    end else if (ctrl_wr) begin
      per_q <= wr_per;
      one_q <= wr_one & ~wr_per;
      ien_q <= wr_ien;
      if (start_evt) begin
        cnt_q      <= '0;
        act_term_q <= term_in;
      end
      if (clear_evt) pend_q <= 1'b0;
    end else if (running) begin
      cnt_q <= next_count(cnt_q, hit_evt, per_q);
      if (hit_evt) begin
        pend_q <= 1'b1;
        if (per_q) act_term_q <= term_in;
        else       one_q      <= 1'b0;
      end
    end
  end

  assert_start_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (cnt_q == '0));
  assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !hit_evt && !ctrl_wr) |=> (cnt_q == $past(cnt_q) + 1'b1));
  assert_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_evt && per_q) |=> (cnt_q == '0 && pend_q && per_q));
  assert_oneshot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_evt && one_q) |=> (!one_q && pend_q && cnt_q == $past(cnt_q)));
  assert_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> (!per_q && !one_q && cnt_q == $past(cnt_q)));
  assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clear_evt |=> !pend_q);
  assert_pend_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q) |-> $past(hit_evt));
  assert_modes_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(per_q && one_q));
endmodule

// File: rtl/mct_regfile.sv
module mct_regfile
  import mct_pkg::*;
#(
  parameter int W  = CNT_W,
  parameter int HW = HALF_W,
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          wr,
  input  logic          rd,
  input  logic [HW-1:0] wdata,
  input  logic [W-1:0]  cnt_i,
  input  logic          per_i,
  input  logic          one_i,
  input  logic          ien_i,
  output logic [HW-1:0] rdata,
  output logic [W-1:0]  term_o,
  output logic          ctrl_wr
);
  logic [HW-1:0] term_lo_q;
  logic [HW-1:0] term_hi_q;
  logic [HW-1:0] shadow_q;
  logic [HW-1:0] rd_mux;
  logic          rd_cnt_lo;

  assign ctrl_wr   = wr && (addr == OFS_CTRL);
  assign rd_cnt_lo = rd && (addr == OFS_CLO);
  assign term_o    = {term_hi_q, term_lo_q};

  always_comb begin
    unique case (addr)
      OFS_CTRL: rd_mux = ctrl_image(per_i, one_i, ien_i);
      OFS_TLO:  rd_mux = term_lo_q;
      OFS_THI:  rd_mux = term_hi_q;
      OFS_CLO:  rd_mux = cnt_i[HW-1:0];
      OFS_CHI:  rd_mux = shadow_q;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      term_lo_q <= '0;
      term_hi_q <= '0;
      shadow_q  <= '0;
      rdata     <= '0;
    end else begin
      if (wr && addr == OFS_TLO) term_lo_q <= wdata;
      if (wr && addr == OFS_THI) term_hi_q <= wdata;
      if (rd_cnt_lo)             shadow_q  <= cnt_i[W-1:HW];
      if (rd)                    rdata     <= rd_mux;
    end
  end

  assert_lo_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_cnt_lo |=> (rdata == $past(cnt_i[HW-1:0])));
  assert_shadow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_cnt_lo |=> (shadow_q == $past(cnt_i[W-1:HW])));
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> $stable(rdata));
  assert_term_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(term_o));
endmodule

// File: rtl/mmio_count_timer.sv
module mmio_count_timer
  import mct_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [HALF_W-1:0] reg_wdata,
  output logic [HALF_W-1:0] reg_rdata,
  output logic              irq
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] term;
  logic             per, one, ien, pend, hit_evt, ctrl_wr;

  mct_regfile #(.W(CNT_W), .HW(HALF_W), .AW(ADDR_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (reg_addr),
    .wr      (reg_wr),
    .rd      (reg_rd),
    .wdata   (reg_wdata),
    .cnt_i   (cnt),
    .per_i   (per),
    .one_i   (one),
    .ien_i   (ien),
    .rdata   (reg_rdata),
    .term_o  (term),
    .ctrl_wr (ctrl_wr)
  );

  mct_core #(.W(CNT_W)) u_core (
    .clk     (clk),
    .rst_n   (rst_n),
    .ctrl_wr (ctrl_wr),
    .wr_per  (reg_wdata[BIT_PER]),
    .wr_one  (reg_wdata[BIT_ONE]),
    .wr_ien  (reg_wdata[BIT_IEN]),
    .term_in (term),
    .cnt_q   (cnt),
    .per_q   (per),
    .one_q   (one),
    .ien_q   (ien),
    .pend_q  (pend),
    .hit_evt (hit_evt)
  );

  assign irq = pend & ien;

  assert_irq_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(hit_evt) || $past(ctrl_wr)));
endmodule

// File: tb/tb_mmio_count_timer.sv
module tb_mmio_count_timer;
  localparam int CLK_P = 10;
  localparam logic [4:0] A_CTRL = 5'h00, A_TLO = 5'h08, A_THI = 5'h0C,
                         A_CLO = 5'h10, A_CHI = 5'h14;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        irq;
  int          n_chk = 0;
  int          n_bad = 0;

  always #(CLK_P/2) clk = ~clk;

  mmio_count_timer dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // All bus tasks start and end just after a falling edge.
  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] v);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    v = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [15:0] v;
    chk("R1 rdata", {16'h0, reg_rdata}, 32'h0);
    chk("R1 irq", {31'h0, irq}, 32'h0);
    rd(A_CTRL, v); chk("R1 ctrl", {16'h0, v}, 32'h0);
    rd(A_TLO, v);  chk("R1 term lo", {16'h0, v}, 32'h0);
    idle(3);
    rd(A_CLO, v);  chk("R1 count stays 0 while idle", {16'h0, v}, 32'h0);
  endtask

  task automatic t_periodic();
    logic [15:0] v;
    wr(A_TLO, 16'd5); wr(A_THI, 16'd0);
    wr(A_CTRL, 16'h0101);
    idle(5); chk("R4 no irq at count==T", {31'h0, irq}, 32'h0);
    idle(1); chk("R4 irq after match", {31'h0, irq}, 32'h1);
    rd(A_CLO, v); chk("R4 wrapped to 0", {16'h0, v}, 32'h0);
    rd(A_CLO, v); chk("R3 count increments", {16'h0, v}, 32'h1);
    rd(A_CTRL, v); chk("R2 ctrl readback", {16'h0, v}, 32'h0101);
    wr(A_CTRL, 16'h0000);
  endtask

  task automatic t_oneshot();
    logic [15:0] v;
    wr(A_TLO, 16'd3);
    wr(A_CTRL, 16'h0102);
    idle(3); chk("R5 no irq before match", {31'h0, irq}, 32'h0);
    idle(1); chk("R5 irq after match", {31'h0, irq}, 32'h1);
    rd(A_CTRL, v); chk("R5 one-shot bit cleared", {16'h0, v}, 32'h0100);
    rd(A_CLO, v); chk("R5 count held at T", {16'h0, v}, 32'h3);
    idle(5);
    rd(A_CLO, v); chk("R5 count still held", {16'h0, v}, 32'h3);
    chk("R7 pending persists", {31'h0, irq}, 32'h1);
    wr(A_CTRL, 16'h0000);
    chk("R7 zero write clears irq", {31'h0, irq}, 32'h0);
  endtask

  task automatic t_gating();
    wr(A_TLO, 16'd1);
    wr(A_CTRL, 16'h0001);
    idle(2); chk("R7 masked irq low", {31'h0, irq}, 32'h0);
    wr(A_CTRL, 16'h0101); chk("R7 enabling shows pending", {31'h0, irq}, 32'h1);
    wr(A_CTRL, 16'h0001); chk("R7 bit8 clear clears pending", {31'h0, irq}, 32'h0);
    wr(A_CTRL, 16'h0101); chk("R7 no stale pending", {31'h0, irq}, 32'h0);
    idle(2); chk("R7 new match raises irq", {31'h0, irq}, 32'h1);
    wr(A_CTRL, 16'h0000);
  endtask

  task automatic t_term_update();
    logic [15:0] v;
    wr(A_TLO, 16'd10); wr(A_THI, 16'd0);
    wr(A_CTRL, 16'h0101);
    idle(2);
    wr(A_TLO, 16'd3);
    idle(1); chk("R8 new terminal not used mid-run", {31'h0, irq}, 32'h0);
    idle(7); chk("R8 old terminal completes", {31'h0, irq}, 32'h1);
    idle(4);
    rd(A_CLO, v); chk("R8 new terminal after wrap", {16'h0, v}, 32'h0);
    rd(A_TLO, v); chk("R8 term lo readback", {16'h0, v}, 32'h3);
    rd(A_THI, v); chk("R8 term hi readback", {16'h0, v}, 32'h0);
    wr(A_CTRL, 16'h0000);
  endtask

  task automatic t_both_bits();
    logic [15:0] v;
    wr(A_TLO, 16'd2);
    wr(A_CTRL, 16'h0103);
    rd(A_CTRL, v); chk("R2 both bits -> periodic", {16'h0, v}, 32'h0101);
    idle(2); chk("R4 irq in periodic", {31'h0, irq}, 32'h1);
    rd(A_CLO, v); chk("R4 period T+1 wrap", {16'h0, v}, 32'h0);
    wr(A_CTRL, 16'h0000);
  endtask

  task automatic t_stop();
    logic [15:0] v;
    wr(A_TLO, 16'd100);
    wr(A_CTRL, 16'h0001);
    idle(5);
    wr(A_CTRL, 16'h0000);
    idle(3);
    rd(A_CLO, v); chk("R6 count frozen", {16'h0, v}, 32'h5);
    rd(A_CTRL, v); chk("R6 stopped ctrl", {16'h0, v}, 32'h0);
    rd(5'h04, v); chk("R10 unmapped reads 0", {16'h0, v}, 32'h0);
    idle(2); chk("R10 rdata holds", {16'h0, reg_rdata}, 32'h0);
  endtask

  task automatic t_coherent();
    logic [15:0] v;
    wr(A_TLO, 16'd5); wr(A_THI, 16'd1);
    wr(A_CTRL, 16'h0001);
    idle(65530);
    rd(A_CLO, v); chk("R9 low half", {16'h0, v}, 32'hFFFA);
    idle(8);
    rd(A_CHI, v); chk("R9 high from shadow", {16'h0, v}, 32'h0);
    rd(A_CLO, v); chk("R9 low after carry", {16'h0, v}, 32'h0004);
    rd(A_CHI, v); chk("R9 high after carry", {16'h0, v}, 32'h0001);
    wr(A_CTRL, 16'h0000);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    t_reset();
    t_periodic();
    t_oneshot();
    t_gating();
    t_term_update();
    t_both_bits();
    t_stop();
    t_coherent();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_P * 190000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule